// File: doc/BRIEF.md
# Systolic FIR Filter with Optional Symmetric Folding

This block is a streaming finite impulse response filter built as a chain of identical multiply-add taps. Each tap holds one signed coefficient in a register of its own. Input samples ripple down a registered delay line that runs alongside the taps. Partial sums pass from tap to tap through one adder register per tap. Because of this, no tap ever adds more than two operands, and no wide adder tree is needed at the end of the chain.

When the symmetric option is enabled, one chain of `TAPS` multipliers implements a filter of length `2*TAPS` whose coefficients mirror about the centre. A pre-adder in every tap sums the two samples that share a coefficient before the multiply. The pipeline advances only on cycles that carry an input sample, so gaps in the input stream do not change the results. Coefficients are written through a small address/data port while no samples are being streamed.

Top module: `sysfir`

## Requirements
- R1: Reset (synchronous, active high) clears every coefficient, every delay and sum register and the output: `out_valid` is 0 and `out_data` is 0 after reset. A filter that is fed samples after reset without any coefficient write produces all-zero output.
- R2: With `cf_we` high, `cf_addr` values 0 to `TAPS-1` load `cf_data` into that tap's coefficient. Address values from `TAPS` up to the top of the `cf_addr` range change nothing at the output.
- R3: Registers advance only on cycles with `in_valid` high. On other cycles `out_data` holds its value and `out_valid` is 0.
- R4: Number the accepted samples from 0. After sample n is accepted, `out_valid` is high for exactly the next cycle if n >= `TAPS+1`; otherwise it stays low.
- R5: With `SYM`=0, after accepted sample n the output `out_data` equals the sum over j=0..`TAPS-1` of c[j]*x[n-`TAPS`-1-j]. Samples with a negative index count as 0.
- R6: With `SYM`=1, the filter has length 2*`TAPS`, with h[j] = h[2*`TAPS`-1-j] = c[j] for j < `TAPS`. After accepted sample n, `out_data` equals the sum over j=0..2*`TAPS`-1 of h[j]*x[n-`TAPS`-1-j].
- R7: Samples, coefficients and sums are signed two's complement and carried at full precision up to `AW` bits. Extreme inputs (most negative sample and coefficient values) give the exact result.
- R8: Inserting idle cycles between samples leaves the sequence of results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf_we | input | 1 | Coefficient write strobe |
| cf_addr | input | $clog2(TAPS)+1 | Tap index for the coefficient write |
| cf_data | input | CW | Signed coefficient value |
| in_valid | input | 1 | Input sample present; advances the pipeline |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result present on `out_data` this cycle |
| out_data | output | AW | Signed filtered result |

## Verification
The bench feeds the same stimulus to a folded instance and a direct instance and compares both against a direct-form convolution. Any error in the two-register sample delay or in the shared far-end sample would show up as a shifted or smeared impulse response. Idle gaps are scattered at random through the stream. A register that advances without an enable would make results drift after the first gap, and a pre-adder that is not held would misalign the mirrored samples. The bench also checks:
- Writes to addresses past the last tap. A decoder that wraps these would corrupt a coefficient.
- Most-negative samples and coefficients. A narrowed pre-adder or a missing sign extension would flip the sign of the result.
- The first valid result. An off-by-one warm-up count would release a partial sum early or drop the first full result.

// File: rtl/sysfir.sv
module sysfir #(
  parameter int TAPS = 4,
  parameter int DW   = 18,
  parameter int CW   = 18,
  parameter int AW   = 64,
  parameter bit SYM  = 1'b1,
  localparam int CAW = $clog2(TAPS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cf_we,
  input  logic [CAW-1:0]       cf_addr,
  input  logic signed [CW-1:0] cf_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  localparam int PW  = DW + 1;
  localparam int MW  = PW + CW;
  localparam int LAT = TAPS + 1;
  localparam int NW  = $clog2(LAT + 1);

  logic signed [DW-1:0] xlast;
  logic [NW-1:0]        cnt;

  for (genvar k = 0; k < TAPS; k++) begin : tap
    logic signed [CW-1:0] coef;
    logic signed [DW-1:0] xa, xb, xin;
    logic signed [PW-1:0] pa;
    logic signed [MW-1:0] mp;
    logic signed [AW-1:0] acc, acc_in;

    if (k == 0) begin : head
      assign xin    = in_data;
      assign acc_in = '0;
    end else begin : body
      assign xin    = tap[k-1].xb;
      assign acc_in = tap[k-1].acc;
    end

    if (SYM) begin : fold
      assign pa = {xa[DW-1], xa} + {xlast[DW-1], xlast};
    end else begin : plain
      assign pa = {xa[DW-1], xa};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        coef <= '0;
        xa   <= '0;
        xb   <= '0;
        mp   <= '0;
        acc  <= '0;
      end else begin
        if (cf_we && cf_addr == CAW'(k)) coef <= cf_data;
        if (in_valid) begin
          xa  <= xin;
          xb  <= xa;
          mp  <= pa * coef;
          acc <= acc_in + {{(AW-MW){mp[MW-1]}}, mp};
        end
      end
    end
  end

  assign xlast    = tap[TAPS-1].xb;
  assign out_data = tap[TAPS-1].acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && (cnt == NW'(LAT));
      if (in_valid && cnt != NW'(LAT)) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sysfir_chk.sv
module sysfir_chk #(
  parameter int TAPS = 4,
  parameter int AW   = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [AW-1:0] out_data
);
  int seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (in_valid && seen < TAPS + 2) seen <= seen + 1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> ($stable(out_data) && !out_valid));

  assert_valid_follows_input_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_no_early_valid_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen == TAPS + 2);

  assert_valid_after_warmup_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seen >= TAPS + 1) |=> out_valid);
endmodule

bind sysfir sysfir_chk #(.TAPS(TAPS), .AW(AW)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sysfir_test.sv
module sysfir_test;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 4;
  localparam int DW  = 18;
  localparam int CW  = 18;
  localparam int AW  = 64;
  localparam int CAW = $clog2(T) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cf_we = 1'b0;
  logic [CAW-1:0] cf_addr = '0;
  logic signed [CW-1:0] cf_data = '0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic ov_s, ov_d;
  logic signed [AW-1:0] od_s, od_d;

  int total = 0;
  int bad = 0;
  int cnt = 0;
  longint hist[0:2047];
  longint c[0:T-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysfir #(.TAPS(T), .DW(DW), .CW(CW), .AW(AW), .SYM(1'b1)) uut (
    .clk(clk), .rst(rst), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .in_valid(in_valid), .in_data(in_data), .out_valid(ov_s), .out_data(od_s));

  sysfir #(.TAPS(T), .DW(DW), .CW(CW), .AW(AW), .SYM(1'b0)) uut_direct (
    .clk(clk), .rst(rst), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .in_valid(in_valid), .in_data(in_data), .out_valid(ov_d), .out_data(od_d));

  function automatic longint ref_y(bit sym, int n);
    int m = n - T - 1;
    int len = sym ? 2*T : T;
    longint s = 0;
    for (int j = 0; j < len; j++) begin
      if (m - j >= 0) s += (j < T ? c[j] : c[2*T-1-j]) * hist[m-j];
    end
    return s;
  endfunction

  task automatic chk_data(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s out_data act=%0d exp=%0d cnt=%0d", tag, act, exp, cnt);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s out_valid act=%0b exp=%0b cnt=%0d", tag, act, exp, cnt);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; cf_we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    for (int k = 0; k < T; k++) c[k] = 0;
  endtask

  task automatic load(int a, longint v);
    cf_we = 1'b1; cf_addr = CAW'(a); cf_data = CW'(v);
    @(negedge clk);
    cf_we = 1'b0;
    if (a < T) c[a] = longint'($signed(CW'(v)));
  endtask

  task automatic push(bit v, longint x, string tag_s, string tag_d);
    bit ev;
    in_valid = v; in_data = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
    ev = 1'b0;
    if (v) begin
      hist[cnt] = longint'($signed(DW'(x)));
      ev = (cnt >= T + 1);
      cnt++;
    end
    chk_bit("R4", ov_s, ev);
    chk_bit("R4", ov_d, ev);
    chk_data(tag_s, od_s, cnt > 0 ? ref_y(1'b1, cnt - 1) : 0);
    chk_data(tag_d, od_d, cnt > 0 ? ref_y(1'b0, cnt - 1) : 0);
  endtask

  task automatic rand_coefs();
    for (int k = 0; k < T; k++) load(k, longint'($signed(CW'($urandom))));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1: reset state
    chk_bit("R1", ov_s, 1'b0); chk_bit("R1", ov_d, 1'b0);
    chk_data("R1", od_s, 0);   chk_data("R1", od_d, 0);

    // R5/R6: continuous random stream
    rand_coefs();
    for (int i = 0; i < 300; i++) push(1'b1, longint'($urandom), "R6", "R5");

    // R8/R3: random idle gaps
    do_reset();
    rand_coefs();
    for (int i = 0; i < 600; i++)
      push(($urandom % 2) == 0, longint'($urandom), "R8", "R8");

    // R2: in-range loads, then out-of-range writes, then impulse
    do_reset();
    for (int k = 0; k < T; k++) load(k, 100 * (k + 1) - 7);
    for (int a = T; a < (1 << CAW); a++) begin
      cf_we = 1'b1; cf_addr = CAW'(a); cf_data = CW'(-12345);
      @(negedge clk);
    end
    cf_we = 1'b0;
    push(1'b1, 1, "R2", "R2");
    for (int i = 0; i < 3*T + 4; i++) push(1'b1, 0, "R2", "R2");

    // R7: extreme values
    do_reset();
    for (int k = 0; k < T; k++) load(k, -(longint'(1) << (CW-1)));
    for (int i = 0; i < 4*T; i++) push(1'b1, -(longint'(1) << (DW-1)), "R7", "R7");
    for (int i = 0; i < 4*T; i++)
      push(1'b1, (i % 2) ? ((longint'(1) << (DW-1)) - 1) : -(longint'(1) << (DW-1)), "R7", "R7");

    // R1: reset mid-stream clears coefficients too
    do_reset();
    chk_data("R1", od_s, 0); chk_data("R1", od_d, 0);
    for (int i = 0; i < 3*T; i++) push(1'b1, longint'($urandom), "R1", "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule